// File: doc/BRIEF.md
# Dual-Edge Pulse Width Capture Unit

The unit times pulses on a single input pin. A free-running 16-bit counter provides the timebase. Its value is latched on every rising and every falling edge of the pin, once the pin has passed through a two-flop synchronizer and an edge detector. Captures go into a small ping-pong buffer. Each entry of the buffer holds one rising-edge slot and one falling-edge slot. A falling edge completes the current entry and moves capture on to the next entry, so software does not need to re-arm the unit between pulses.

In absolute mode the slots hold timestamps, and software subtracts them to get a width. In delta mode the counter restarts at every captured edge, so each slot directly holds the time since the previous edge. The counter either advances on every clock or only on cycles where a tick input is high, which lets a faster reference be brought in as a clock enable. Three sticky flags can be set, cleared and forced through a small register bus: edge capture, counter rollover and entry overwrite. The interrupt output is driven from the capture flag and, when enabled, from the rollover flag.

Top module: `pwc_top`

## Requirements
- R1: After reset, the control register (address 0), the flag register (address 1) and the counter (address 4) read zero, and irq_o is low.
- R2: With control bit 0 (run) set and control bit 3 (tick source) clear, the counter advances by one every clock cycle. With run clear, the counter holds its value.
- R3: With control bit 3 set, the counter advances only on cycles where tick_i is high. A 40-cycle pulse measured with a tick on every fourth cycle gives a width of 10.
- R4: Each pin transition is captured exactly once, after a two-flop synchronizer. In absolute mode, the fall slot minus the rise slot (modulo 2^16) equals the number of clock cycles the pin was high, including a one-cycle pulse.
- R5: Entry e keeps its rise capture at address 8+2e and its fall capture at address 9+2e. Capture starts at entry 0 after reset, and each captured falling edge moves capture to the next entry, wrapping after the last one.
- R6: With control bit 1 (delta) set, the counter reads zero on the cycle after every captured edge. A pulse high for W cycles therefore stores W-1 in its fall slot.
- R7: Flag bit 0 is set by a captured rising edge when control bit 2 is clear, and by a captured falling edge when control bit 2 is set. The other edge leaves it unchanged. This flag drives irq_o.
- R8: Writing a one to a bit at address 2 clears that flag. Writing a one to a bit at address 3 sets it. A flag forced this way drives irq_o in the same way as a hardware-set flag.
- R9: Flag bit 2 is set when a rising edge lands in an entry whose completed pair has not been read. Reading either slot of an entry marks that entry as read.
- R10: When the counter wraps from 0xFFFF to 0, flag bit 1 is set. This flag raises irq_o only while control bit 4 is set.
- R11: While run is clear, pin edges store nothing, leave every slot unchanged and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pulse input to be measured |
| tick_i | input | 1 | Count enable used when the tick source is selected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; marks an entry read when a slot is addressed |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of pulses, each with its own width and mode, exercises the capture path. In absolute mode the widths run from a single cycle to several hundred cycles, and delta-mode pulses are mixed in. Because the entries alternate, a pointer that fails to advance, or a slot that is wired to the wrong edge, shows up as a wrong difference. A one-cycle pulse in both modes separates an off-by-one in the synchronizer or in the restart from a correct result. A tick pattern of one cycle in four separates a counter that counts every cycle from one that respects the enable. Directed sequences then cover the following:
- edge selection, by observing the flag between the two edges of a pulse;
- an unread entry overwritten by a third pulse;
- pulses while stopped;
- a full counter wrap with the rollover interrupt enabled and then disabled.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Control word; the first member is the most significant bit.
  typedef struct packed {
    logic roll_ie;      // bit 4: rollover flag may raise the interrupt
    logic tick_src;     // bit 3: count only on tick_i
    logic irq_on_fall;  // bit 2: capture flag on the falling edge
    logic delta;        // bit 1: restart the counter at each captured edge
    logic run;          // bit 0: counting and capture enabled
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Flag bit positions
  localparam int unsigned FL_CAP  = 0;
  localparam int unsigned FL_ROLL = 1;
  localparam int unsigned FL_OVW  = 2;
  localparam int unsigned NFLAG   = 3;

  // Register addresses
  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_FLAG      = 1;
  localparam int unsigned A_CLR       = 2;
  localparam int unsigned A_FRC       = 3;
  localparam int unsigned A_CNT       = 4;
  localparam int unsigned A_SLOT_BASE = 8;

endpackage

// File: rtl/pwc_edge.sv
module pwc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // sh[0..STAGES-1] form the synchronizer, and sh[STAGES] holds the previous level.
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/pwc_timebase.sv
module pwc_timebase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_sel_i,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = run_i & (tick_sel_i ? tick_i : 1'b1);

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwc_capbuf.sv
module pwc_capbuf #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ENTRIES = 2,
  parameter int unsigned PTR_W   = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cap_rise_i,
  input  logic                            cap_fall_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic                            rd_hit_i,
  input  logic [PTR_W-1:0]                rd_idx_i,
  output logic [ENTRIES-1:0][CNT_W-1:0]   rise_o,
  output logic [ENTRIES-1:0][CNT_W-1:0]   fall_o,
  output logic [PTR_W-1:0]                ptr_o,
  output logic                            ovw_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [ENTRIES-1:0] full_vec;

  always_comb begin
    ptr_d = ptr_q;
    if (cap_fall_i) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             hit;
    logic [CNT_W-1:0] r_q, r_d, f_q, f_d;
    logic             full_q, full_d;

    assign hit = (ptr_q == PTR_W'(e));

    always_comb begin
      r_d    = r_q;
      f_d    = f_q;
      full_d = full_q;
      if (rd_hit_i && (rd_idx_i == PTR_W'(e))) full_d = 1'b0;
      if (hit && cap_rise_i) r_d = cnt_i;
      if (hit && cap_fall_i) begin
        f_d    = cnt_i;
        full_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q    <= '0;
        f_q    <= '0;
        full_q <= 1'b0;
      end else begin
        r_q    <= r_d;
        f_q    <= f_d;
        full_q <= full_d;
      end
    end

    assign rise_o[e]   = r_q;
    assign fall_o[e]   = f_q;
    assign full_vec[e] = full_q;
  end

  assign ptr_o = ptr_q;
  assign ovw_o = cap_rise_i & full_vec[ptr_q];

endmodule

// File: rtl/pwc_top.sv
module pwc_top #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ENTRIES     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  import pwc_pkg::*;

  localparam int unsigned PTR_W    = $clog2(ENTRIES);
  localparam int unsigned SLOT_END = A_SLOT_BASE + 2 * ENTRIES;

  ctrl_t              ctrl_q, ctrl_d;
  logic [NFLAG-1:0]   flags_q, flags_d, flag_set, flag_clr, flag_frc;
  logic               rise, fall, cap_rise, cap_fall, restart;
  logic               run_en, wrap, ovw;
  logic [CNT_W-1:0]   cnt;
  logic [PTR_W-1:0]   buf_ptr, rd_idx;
  logic [ADDR_W-1:0]  slot_off;
  logic               in_slot, rd_hit;
  logic [ENTRIES-1:0][CNT_W-1:0] rise_slots, fall_slots;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata_i[CNT_W-1:CTRL_W];

  // Edge detection and capture gating
  pwc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign run_en   = ctrl_q.run;
  assign cap_rise = rise & run_en;
  assign cap_fall = fall & run_en;
  assign restart  = ctrl_q.delta & (cap_rise | cap_fall);

  pwc_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_en),
    .tick_sel_i (ctrl_q.tick_src),
    .tick_i     (tick_i),
    .restart_i  (restart),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  // Register decode
  assign in_slot  = (reg_addr_i >= ADDR_W'(A_SLOT_BASE)) && (reg_addr_i < ADDR_W'(SLOT_END));
  assign slot_off = reg_addr_i - ADDR_W'(A_SLOT_BASE);
  assign rd_idx   = PTR_W'(slot_off >> 1);
  assign rd_hit   = reg_rd_i & in_slot;

  pwc_capbuf #(.CNT_W(CNT_W), .ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_rise_i (cap_rise),
    .cap_fall_i (cap_fall),
    .cnt_i      (cnt),
    .rd_hit_i   (rd_hit),
    .rd_idx_i   (rd_idx),
    .rise_o     (rise_slots),
    .fall_o     (fall_slots),
    .ptr_o      (buf_ptr),
    .ovw_o      (ovw)
  );

  // Control and flag next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (reg_wr_i && reg_addr_i == ADDR_W'(A_CTRL)) ctrl_d = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_comb begin
    flag_set          = '0;
    flag_set[FL_CAP]  = ctrl_q.irq_on_fall ? cap_fall : cap_rise;
    flag_set[FL_ROLL] = wrap;
    flag_set[FL_OVW]  = ovw;
    flag_clr = (reg_wr_i && reg_addr_i == ADDR_W'(A_CLR)) ? reg_wdata_i[NFLAG-1:0] : '0;
    flag_frc = (reg_wr_i && reg_addr_i == ADDR_W'(A_FRC)) ? reg_wdata_i[NFLAG-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set | flag_frc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      flags_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      flags_q <= flags_d;
    end
  end

  assign irq_o = flags_q[FL_CAP] | (flags_q[FL_ROLL] & ctrl_q.roll_ie);

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_CTRL)) begin
      reg_rdata_o[CTRL_W-1:0] = ctrl_q;
    end else if (reg_addr_i == ADDR_W'(A_FLAG)) begin
      reg_rdata_o[NFLAG-1:0] = flags_q;
    end else if (reg_addr_i == ADDR_W'(A_CNT)) begin
      reg_rdata_o = cnt;
    end else if (in_slot) begin
      reg_rdata_o = slot_off[0] ? fall_slots[rd_idx] : rise_slots[rd_idx];
    end
  end

endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PTR_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             restart,
  input logic             cap_fall,
  input logic [CNT_W-1:0] cnt,
  input logic [PTR_W-1:0] ptr,
  input logic             flag_cap,
  input logic             flag_roll,
  input logic             irq
);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == $past(cnt)));

  // R6
  delta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

  // R10
  roll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cnt) == {CNT_W{1'b1}}) && (cnt == '0) && !$past(restart)) |-> flag_roll);

  // R7
  cap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_cap |-> irq);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fall |=> (ptr != $past(ptr)));

endmodule

bind pwc_top pwc_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_en),
  .restart   (restart),
  .cap_fall  (cap_fall),
  .cnt       (cnt),
  .ptr       (buf_ptr),
  .flag_cap  (flags_q[0]),
  .flag_roll (flags_q[1]),
  .irq       (irq_o)
);

// File: tb/pwc_top_bench.sv
`timescale 1ns/1ps
module pwc_top_bench;

  logic        clk;
  logic        rst_n, pin, tick, wr, rd;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;
  int          errors, checks, cyc;
  bit          done;

  // {delta, width, expected stored value}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 16'd3,   16'd3},
    {1'b0, 16'd1,   16'd1},
    {1'b0, 16'd57,  16'd57},
    {1'b0, 16'd300, 16'd300},
    {1'b1, 16'd1,   16'd0},
    {1'b1, 16'd4,   16'd3},
    {1'b1, 16'd90,  16'd89},
    {1'b0, 16'd2,   16'd2}
  };

  pwc_top u_pwc_top (
    .clk (clk), .rst_n (rst_n), .pin_i (pin), .tick_i (tick),
    .reg_wr_i (wr), .reg_rd_i (rd), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(negedge clk) begin
    cyc  = cyc + 1;
    tick = (cyc % 4 == 0);
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] w);
    @(negedge clk);
    pin = 1'b1;
    repeat (w) @(negedge clk);
    pin = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] a, b, r, f;
    logic [15:0] keep [4];
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; pin = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(4'd0, a); check("R1 ctrl", a, 16'd0);
    rd_reg(4'd1, a); check("R1 flags", a, 16'd0);
    rd_reg(4'd4, a); check("R1 count", a, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);

    // R2 free count and hold
    wr_reg(4'd0, 16'h0001);
    rd_reg(4'd4, a); rd_reg(4'd4, b);
    check("R2 step", b - a, 16'd2);
    wr_reg(4'd0, 16'h0000);
    rd_reg(4'd4, a); repeat (5) @(negedge clk); rd_reg(4'd4, b);
    check("R2 hold", b, a);

    // Vector table: R4 absolute, R6 delta, R5 ping-pong placement
    for (int i = 0; i < 8; i++) begin
      logic        dm;
      logic [15:0] w, exp, act;
      dm  = VEC[i][32];
      w   = VEC[i][31:16];
      exp = VEC[i][15:0];
      wr_reg(4'd0, {14'd0, dm, 1'b1});
      pulse(w);
      rd_reg(4'(8 + 2 * (i % 2)), r);
      rd_reg(4'(9 + 2 * (i % 2)), f);
      act = dm ? f : f - r;
      check(dm ? "R6 R5 delta width" : "R4 R5 absolute width", act, exp);
    end

    // R3 tick source: 40 cycles with one tick in four -> 10
    wr_reg(4'd0, 16'h0009);
    pulse(16'd40);
    rd_reg(4'd8, r); rd_reg(4'd9, f);
    check("R3 tick width", f - r, 16'd10);

    // R7 edge select (entries 1 then 0 fill)
    wr_reg(4'd0, 16'h0001);
    wr_reg(4'd2, 16'h0007);
    @(negedge clk); pin = 1'b1; repeat (6) @(negedge clk);
    rd_reg(4'd1, a); check("R7 rise sets flag", a & 16'h1, 16'h1);
    check("R7 irq", {15'd0, irq}, 16'd1);
    wr_reg(4'd2, 16'h0001);
    pin = 1'b0; repeat (6) @(negedge clk);
    rd_reg(4'd1, a); check("R7 fall ignored", a & 16'h1, 16'h0);
    wr_reg(4'd0, 16'h0005);
    pin = 1'b1; repeat (6) @(negedge clk);
    rd_reg(4'd1, a); check("R7 rise ignored", a & 16'h1, 16'h0);
    pin = 1'b0; repeat (6) @(negedge clk);
    rd_reg(4'd1, a); check("R7 fall sets flag", a & 16'h1, 16'h1);
    for (int s = 8; s < 12; s++) rd_reg(4'(s), a);

    // R8 clear and force
    wr_reg(4'd2, 16'h0007);
    check("R8 cleared irq", {15'd0, irq}, 16'd0);
    wr_reg(4'd3, 16'h0001);
    check("R8 forced irq", {15'd0, irq}, 16'd1);
    wr_reg(4'd2, 16'h0001);
    check("R8 clear drops irq", {15'd0, irq}, 16'd0);
    wr_reg(4'd3, 16'h0002);
    rd_reg(4'd1, a); check("R8 forced rollover flag", a, 16'h2);
    check("R8 rollover masked", {15'd0, irq}, 16'd0);
    wr_reg(4'd2, 16'h0007);

    // R11 stopped: no captures
    wr_reg(4'd0, 16'h0000);
    for (int s = 0; s < 4; s++) rd_reg(4'(8 + s), keep[s]);
    pulse(16'd12);
    for (int s = 0; s < 4; s++) begin
      rd_reg(4'(8 + s), a);
      check("R11 slot unchanged", a, keep[s]);
    end
    rd_reg(4'd1, a); check("R11 no flag", a, 16'd0);

    // R9 overwrite of unread entry
    wr_reg(4'd0, 16'h0001);
    pulse(16'd5); pulse(16'd6);
    rd_reg(4'd1, a); check("R9 no overwrite yet", a & 16'h4, 16'h0);
    pulse(16'd7);
    rd_reg(4'd1, a); check("R9 overwrite flag", a & 16'h4, 16'h4);
    for (int s = 8; s < 12; s++) rd_reg(4'(s), a);
    wr_reg(4'd2, 16'h0007);
    pulse(16'd8);
    rd_reg(4'd1, a); check("R9 read entry frees it", a & 16'h4, 16'h0);

    // R10 rollover
    wr_reg(4'd2, 16'h0007);
    repeat (65540) @(negedge clk);
    rd_reg(4'd1, a); check("R10 rollover flag", a & 16'h2, 16'h2);
    check("R10 irq masked", {15'd0, irq}, 16'd0);
    wr_reg(4'd0, 16'h0011);
    check("R10 irq enabled", {15'd0, irq}, 16'd1);
    wr_reg(4'd2, 16'h0002);
    check("R10 irq cleared", {15'd0, irq}, 16'd0);

    finish_run();
  end

endmodule